// File: doc/BRIEF.md
# DMA Peripheral-to-Memory Write Gatherer

This block sits in the peripheral-to-memory path of one DMA channel. A paced peripheral offers one element at a time at its own width of 1, 2 or 4 bytes. Each accepted element is placed into a 32-byte staging window at the byte lanes given by its destination address. When a flush condition is met, the collected bytes go to system memory through a write port that can carry anything from a single byte up to a full 32-byte burst.

A transfer is armed by a one-cycle `start` pulse. This pulse samples the destination address, the element count, the element width and the buffering mode. In buffered mode, collection stops and a flush begins on any of these events: the window end is reached, the peripheral drops its request, a higher-priority request is pending, or the element count runs out. Each flush is cut into naturally aligned power-of-two pieces. A window that was filled from an aligned start leaves as one 32-byte write. In bypass mode, each element is written out alone before the next one is taken. When the count is exhausted and the last flush has been accepted, a one-cycle done pulse is raised.

Top module: `dma_wr_gather`

## Requirements
- R1: After reset, `per_ack`, `mem_wr_valid` and `xfer_done` are all low.
- R2: With buffering off (`buf_en`=0 at start), every element produces its own memory write at its own address and element size, before the next element is acknowledged.
- R3: `per_ack` is never high while a memory write is pending (`mem_wr_valid`=1). Acceptance resumes only after the last piece of a flush has been accepted.
- R4: A 32-byte window filled from a 32-byte-aligned destination is flushed as one write of 32 bytes, with all 32 byte enables set.
- R5: Every flush piece has a power-of-two size no larger than the remaining bytes, and its address is aligned to that size. Pieces leave in ascending address order, starting at the first unflushed byte, and each piece is the largest size that meets these rules.
- R6: When the peripheral deasserts `per_req` with bytes pending, those bytes are flushed. Collection then resumes at the next address when the request returns.
- R7: While `hi_pri_pend` is high, no element is acknowledged, and any pending bytes are flushed.
- R8: When the element count reaches zero, the remaining bytes are flushed. `xfer_done` then pulses for exactly one cycle, two clock edges after the final piece is accepted.
- R9: `elem_size` codes 0, 1 and 2 select 1, 2 and 4 bytes, and code 3 selects 4 bytes. Byte i of `per_data` (bits 8i+7..8i) lands at destination address plus i, and the write pointer advances by the element width.
- R10: The destination address advances by exactly the number of bytes flushed, so successive flushes cover contiguous memory without gaps or overlap.
- R11: While `mem_wr_valid` is high and `mem_wr_ready` is low, the address and byte enables hold steady, and the command stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arms a transfer when idle (one-cycle pulse) |
| dest_addr | input | AW | First destination byte address, aligned to the element width |
| elem_count | input | CW | Number of elements in the transfer |
| buf_en | input | 1 | 1 = gather into window, 0 = write each element through |
| elem_size | input | 2 | Element width code: 0=1 B, 1=2 B, 2 or 3=4 B |
| per_req | input | 1 | Peripheral request level |
| per_data | input | 8*EW | Element data, byte 0 in bits 7..0 |
| hi_pri_pend | input | 1 | A higher-priority request is pending |
| per_ack | output | 1 | Element captured on the previous edge |
| mem_wr_valid | output | 1 | Memory write command valid |
| mem_wr_ready | input | 1 | Memory port accepts the command |
| mem_wr_addr | output | AW | Byte address of the piece |
| mem_wr_bytes | output | log2(WIN)+1 | Piece length in bytes (1..WIN) |
| mem_wr_be | output | WIN | Byte enables over the 32-byte window lanes |
| mem_wr_data | output | 8*WIN | Window contents, lane l in bits 8l+7..8l |
| xfer_done | output | 1 | One-cycle pulse when the transfer is complete |

## Verification
A wrong collect pointer shows up at the ports almost at once. Within the same flush, the memory writes come out with a wrong address, a misaligned piece size, or bytes landing in the wrong memory locations. A wrong flush pointer gives gaps or overlaps between consecutive pieces, and these show in the written memory image once the flush has drained. A control state that forgets to block acceptance makes `per_ack` coincide with a pending write, or with a raised priority flag, in the very next cycle. A wrong element counter shows as a missing, early or repeated done pulse, or as elements taken beyond the programmed count.

// File: rtl/dwg_pkg.sv
package dwg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2
  } dwg_state_e;
endpackage

// File: rtl/gather_lanes.sv
// Byte-lane staging window: each lane is addressed by the low address bits.
module gather_lanes #(
  parameter int WIN = 32,
  parameter int EW  = 4,
  localparam int OW  = $clog2(WIN),
  localparam int EBW = $clog2(EW) + 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [OW-1:0]     off,
  input  logic [EBW-1:0]    nbytes,
  input  logic [8*EW-1:0]   din,
  output logic [8*WIN-1:0]  window
);
  logic [7:0] lane [WIN];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < EW; i++) begin
        if (i < int'(nbytes)) lane[OW'(int'(off) + i)] <= din[8*i +: 8];
      end
    end
  end

  for (genvar l = 0; l < WIN; l++) begin : g_out
    assign window[8*l +: 8] = lane[l];
  end
endmodule

// File: rtl/gather_piece.sv
// Picks the largest naturally aligned power-of-two piece at the flush pointer.
module gather_piece #(
  parameter int WIN = 32,
  localparam int OW = $clog2(WIN)
) (
  input  logic [OW-1:0]  off,
  input  logic [OW:0]    rem,
  output logic [OW:0]    bytes,
  output logic [WIN-1:0] be
);
  always_comb begin
    bytes = (OW+1)'(1);
    for (int k = 0; k <= OW; k++) begin
      if ((int'(rem) >= (1 << k)) && ((int'(off) % (1 << k)) == 0))
        bytes = (OW+1)'(1 << k);
    end
  end

  always_comb begin
    for (int l = 0; l < WIN; l++)
      be[l] = (l >= int'(off)) && (l < int'(off) + int'(bytes));
  end
endmodule

// File: rtl/dma_wr_gather.sv
module dma_wr_gather
  import dwg_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int WIN = 32,
  parameter int EW  = 4,
  localparam int OW  = $clog2(WIN),
  localparam int EBW = $clog2(EW) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     dest_addr,
  input  logic [CW-1:0]     elem_count,
  input  logic              buf_en,
  input  logic [1:0]        elem_size,
  input  logic              per_req,
  input  logic [8*EW-1:0]   per_data,
  input  logic              hi_pri_pend,
  output logic              per_ack,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [OW:0]       mem_wr_bytes,
  output logic [WIN-1:0]    mem_wr_be,
  output logic [8*WIN-1:0]  mem_wr_data,
  output logic              xfer_done
);
  dwg_state_e       state;
  logic [AW-1:0]    cur_addr;   // next byte to collect
  logic [AW-1:0]    fl_addr;    // first byte not yet flushed
  logic [CW-1:0]    cnt;
  logic [1:0]       size_q;
  logic             bufen_q;
  logic [EBW-1:0]   eb;
  logic [OW:0]      pend;
  logic [OW:0]      piece;
  logic             full, flush_go, take;

  always_comb begin
    if (int'(size_q) >= $clog2(EW)) eb = EBW'(EW);
    else                            eb = EBW'(1 << size_q);
  end

  assign pend     = (OW+1)'(cur_addr - fl_addr);
  assign full     = (pend != '0) && (cur_addr[OW-1:0] == '0);
  assign flush_go = (pend != '0) &&
                    (full || !per_req || hi_pri_pend || cnt == '0 || !bufen_q);
  assign take     = !flush_go && per_req && !hi_pri_pend && cnt != '0;

  gather_lanes #(.WIN(WIN), .EW(EW)) u_lanes (
    .clk    (clk),
    .we     (state == ST_FILL && take),
    .off    (cur_addr[OW-1:0]),
    .nbytes (eb),
    .din    (per_data),
    .window (mem_wr_data)
  );

  gather_piece #(.WIN(WIN)) u_piece (
    .off   (fl_addr[OW-1:0]),
    .rem   (pend),
    .bytes (piece),
    .be    (mem_wr_be)
  );

  assign mem_wr_addr  = fl_addr;
  assign mem_wr_bytes = piece;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      per_ack      <= 1'b0;
      mem_wr_valid <= 1'b0;
      xfer_done    <= 1'b0;
      cur_addr     <= '0;
      fl_addr      <= '0;
      cnt          <= '0;
      size_q       <= '0;
      bufen_q      <= 1'b0;
    end else begin
      per_ack   <= 1'b0;
      xfer_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            cur_addr <= dest_addr;
            fl_addr  <= dest_addr;
            cnt      <= elem_count;
            size_q   <= elem_size;
            bufen_q  <= buf_en;
            state    <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (flush_go) begin
            mem_wr_valid <= 1'b1;
            state        <= ST_DRAIN;
          end else if (take) begin
            cur_addr <= cur_addr + AW'(eb);
            cnt      <= cnt - 1'b1;
            per_ack  <= 1'b1;
          end else if (cnt == '0 && pend == '0) begin
            xfer_done <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_DRAIN: begin
          if (mem_wr_ready) begin
            fl_addr <= fl_addr + AW'(piece);
            if (piece == pend) begin
              mem_wr_valid <= 1'b0;
              state        <= ST_FILL;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  ack_drain_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr_valid && per_ack));

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && !mem_wr_ready |=>
      mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_be));

  // R5
  piece_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> ($countones(mem_wr_bytes) == 1) &&
      ((mem_wr_addr[OW-1:0] & OW'(mem_wr_bytes - 1'b1)) == '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  // R7
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    hi_pri_pend |=> !per_ack);
endmodule

// File: tb/dma_wr_gather_test.sv
module dma_wr_gather_test;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [31:0]   dest_addr = '0;
  logic [15:0]   elem_count = '0;
  logic          buf_en = 1'b1;
  logic [1:0]    elem_size = '0;
  logic          per_req = 1'b0;
  logic [31:0]   per_data = '0;
  logic          hi_pri_pend = 1'b0;
  logic          per_ack;
  logic          mem_wr_valid;
  logic          mem_wr_ready = 1'b1;
  logic [31:0]   mem_wr_addr;
  logic [5:0]    mem_wr_bytes;
  logic [31:0]   mem_wr_be;
  logic [255:0]  mem_wr_data;
  logic          xfer_done;

  dma_wr_gather uut (
    .clk(clk), .rst(rst), .start(start), .dest_addr(dest_addr),
    .elem_count(elem_count), .buf_en(buf_en), .elem_size(elem_size),
    .per_req(per_req), .per_data(per_data), .hi_pri_pend(hi_pri_pend),
    .per_ack(per_ack), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_bytes(mem_wr_bytes), .mem_wr_be(mem_wr_be),
    .mem_wr_data(mem_wr_data), .xfer_done(xfer_done)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] shadow [0:1023];
  int w_addr [0:63];
  int w_bytes [0:63];
  logic [31:0] w_be [0:63];
  int nw = 0, sent = 0, limit = 0, done_cnt = 0;
  int hi_at = -1, hi_cnt = 0, bad_ack = 0;
  bit stall = 1'b0;

  function automatic logic [7:0] pat(int idx, int i);
    return 8'(idx * 7 + i * 3 + 5);
  endfunction

  // Memory port, peripheral and priority models, all updated away from the active edge.
  always @(negedge clk) begin
    if (mem_wr_valid && mem_wr_ready) begin
      for (int l = 0; l < 32; l++)
        if (mem_wr_be[l]) shadow[(int'(mem_wr_addr) & ~31) + l] = mem_wr_data[8*l +: 8];
      if (nw < 64) begin
        w_addr[nw] = int'(mem_wr_addr);
        w_bytes[nw] = int'(mem_wr_bytes);
        w_be[nw] = mem_wr_be;
      end
      nw++;
    end
    if (xfer_done) done_cnt++;
    if (hi_pri_pend && per_ack) bad_ack++;
    mem_wr_ready = stall ? ~mem_wr_ready : 1'b1;
    if (per_ack) sent++;
    if (hi_cnt > 0) hi_cnt--;
    if (hi_at >= 0 && sent == hi_at) begin
      hi_cnt = 4;
      hi_at = -1;
    end
    hi_pri_pend = (hi_cnt != 0);
    per_req = (sent < limit);
    for (int i = 0; i < 4; i++) per_data[8*i +: 8] = pat(sent, i);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic go(int dest, int cnt, int sz, bit en);
    @(posedge clk); #2;
    nw = 0; sent = 0; done_cnt = 0; bad_ack = 0;
    dest_addr = 32'(dest); elem_count = 16'(cnt);
    elem_size = 2'(sz); buf_en = en; limit = cnt;
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int t = 0; t < 2000 && done_cnt == 0; t++) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  task automatic check_wr(int k, int addr, int bytes, string req);
    check(nw > k && w_addr[k] == addr, req, (nw > k) ? w_addr[k] : -1, addr);
    check(nw > k && w_bytes[k] == bytes, req, (nw > k) ? w_bytes[k] : -1, bytes);
  endtask

  task automatic check_mem(int dest, int cnt, int w, string req);
    int bad = 0, first_a = 0, first_e = 0;
    for (int idx = 0; idx < cnt; idx++)
      for (int i = 0; i < w; i++)
        if (shadow[dest + idx*w + i] !== pat(idx, i)) begin
          if (bad == 0) begin
            first_a = int'(shadow[dest + idx*w + i]);
            first_e = int'(pat(idx, i));
          end
          bad++;
        end
    check(bad == 0, req, first_a, first_e);
  endtask

  task automatic t_reset();
    // R1
    check(per_ack == 1'b0, "R1 ack", int'(per_ack), 0);
    check(mem_wr_valid == 1'b0, "R1 valid", int'(mem_wr_valid), 0);
    check(xfer_done == 1'b0, "R1 done", int'(xfer_done), 0);
  endtask

  task automatic t_aligned_full();
    // R4, R9: 8 x 4 bytes from aligned 0x40
    go(32'h40, 8, 2, 1'b1);
    wait_done();
    check(nw == 1, "R4 one burst", nw, 1);
    check_wr(0, 32'h40, 32, "R4 burst");
    check(w_be[0] == 32'hFFFF_FFFF, "R4 be", int'(w_be[0]), 32'hFFFF_FFFF);
    check_mem(32'h40, 8, 4, "R9 data 4B");
    check(done_cnt == 1, "R8 done once", done_cnt, 1);
  endtask

  task automatic t_unaligned();
    // R5, R10: 7 x 4 bytes from 0x84 fill to 0xA0
    go(32'h84, 7, 2, 1'b1);
    wait_done();
    check(nw == 3, "R5 piece count", nw, 3);
    check_wr(0, 32'h84, 4, "R5 piece0");
    check_wr(1, 32'h88, 8, "R5 piece1");
    check_wr(2, 32'h90, 16, "R10 piece2");
    check_mem(32'h84, 7, 4, "R5 data");
  endtask

  task automatic t_bypass();
    // R2: each 2-byte element written through on its own
    go(32'h100, 5, 1, 1'b0);
    wait_done();
    check(nw == 5, "R2 write per element", nw, 5);
    for (int k = 0; k < 5; k++) check_wr(k, 32'h100 + 2*k, 2, "R2 element write");
    check_mem(32'h100, 5, 2, "R2 data");
  endtask

  task automatic t_req_drop();
    // R6: peripheral stops after 3 bytes, then resumes
    go(32'h20, 20, 0, 1'b1);
    limit = 3;
    repeat (30) @(posedge clk);
    check(nw == 2, "R6 flush on drop", nw, 2);
    check_wr(0, 32'h20, 2, "R6 piece0");
    check_wr(1, 32'h22, 1, "R6 piece1");
    check(done_cnt == 0, "R6 not done yet", done_cnt, 0);
    limit = 20;
    wait_done();
    check(nw == 6, "R10 total pieces", nw, 6);
    check_wr(2, 32'h23, 1, "R10 resume addr");
    check_wr(3, 32'h24, 4, "R5 piece3");
    check_wr(4, 32'h28, 8, "R5 piece4");
    check_wr(5, 32'h30, 4, "R8 last piece");
    check_mem(32'h20, 20, 1, "R9 data 1B");
    check(done_cnt == 1, "R8 done once", done_cnt, 1);
  endtask

  task automatic t_hi_pri();
    // R7: priority raised after 3 elements
    go(32'h200, 8, 2, 1'b1);
    hi_at = 3;
    wait_done();
    check(bad_ack == 0, "R7 no ack under priority", bad_ack, 0);
    check(nw == 4, "R7 piece count", nw, 4);
    check_wr(0, 32'h200, 8, "R7 piece0");
    check_wr(1, 32'h208, 4, "R7 piece1");
    check_wr(2, 32'h20C, 4, "R7 piece2");
    check_wr(3, 32'h210, 16, "R7 piece3");
    check_mem(32'h200, 8, 4, "R7 data");
  endtask

  task automatic t_stall();
    // R11, R9: 2-byte elements with memory ready toggling
    stall = 1'b1;
    go(32'h302, 15, 1, 1'b1);
    wait_done();
    stall = 1'b0;
    check(nw == 4, "R11 piece count", nw, 4);
    check_wr(0, 32'h302, 2, "R11 piece0");
    check_wr(1, 32'h304, 4, "R11 piece1");
    check_wr(2, 32'h308, 8, "R11 piece2");
    check_wr(3, 32'h310, 16, "R11 piece3");
    check_mem(32'h302, 15, 2, "R9 data 2B");
    check(done_cnt == 1, "R8 done once", done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_aligned_full();
    t_unaligned();
    t_bypass();
    t_req_drop();
    t_hi_pri();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule